// File: doc/BRIEF.md
# Status doubleword stack-pull controller

This controller carries out the restore half of a load-status operation. When `start` is pulsed it captures an instruction word and a 64-bit status-stack pointer. It then picks one of three paths from the pointer's word count. A count between 1 and 27 raises a trap. A count of zero fetches a 64-bit status doubleword from the fixed memory words 2 and 3. A count of 28 or more pops the doubleword from the memory stack and moves the pointer by 28. A set top instruction bit overrides all three paths with a nonexistent-instruction trap.

After a successful fetch the controller loads the processor status fields from the doubleword. The three interrupt-inhibit bits are merged with an inclusive OR, so this operation can set them but never clear them. Two instruction flags can then request a change to an interrupt level. For the clear-and-arm and clear-and-disarm requests, the whole operation waits until the interrupt system accepts. Memory is read over a word-wide valid/ready port in two beats. All status and pointer updates take effect in the single cycle that raises `done`.

Top module: `status_pull_ctrl`

Throughout, doubleword bit n is `ed[63-n]`: the first word read forms bits 0–31 (`ed[63:32]`) and the second forms bits 32–63. Instruction bit n is `instr[31-n]`.

Pointer layout: `ptr[63:32]` is the top-of-stack address, `ptr[31]` is the space-overflow flag, `ptr[30:16]` is the space count, `ptr[15]` is a held bit, and `ptr[14:0]` is the word count.

## Requirements
- R1: A synchronous active-high `rst` returns the controller to idle. It drops `mem_valid`, `int_req`, `done`, `trap_valid`, `ptr_wr` and `pdf_clr`, cancels any pending interrupt-level request, and clears every status output and `ptr_out` to zero.
- R2: If `instr[31]` (instruction bit 0) is 1, `trap_valid` pulses for one cycle, one cycle after `start`, with `trap_vec` = 0x40 and `trap_cc2` = 0. No memory read takes place, and the status outputs and `ptr_out` stay unchanged.
- R3: If `instr[31]` is 0 and the word count `ptr_in[14:0]` is between 1 and 27, `trap_valid` pulses one cycle after `start` with `trap_vec` = 0x4D and `trap_cc2` = 1. No read takes place, `ptr_wr` stays low and the status is unchanged.
- R4: With a word count of 0, the controller reads address 2 and then address 3. `ptr_wr` stays low.
- R5: With a word count of 28 or more, the controller reads address TSA−24 and then TSA+1, where TSA = `ptr_in[63:32]`. Together with `done`, `ptr_wr` pulses, and `ptr_out` carries TSA−28, the word count minus 28, and the space count plus 28.
- R6: On a pop, if the space count plus 28 exceeds 32767, `ptr_out[31]` is set to 1 and the count keeps its low 15 bits. A flag that is already 1 stays 1. `ptr_out[15]` always equals `ptr_in[15]`.
- R7: A read beat completes in a cycle where both `mem_valid` and `mem_ready` are high. While `mem_ready` is low, `mem_valid` and `mem_addr` hold their values.
- R8: At commit, the status outputs load as follows:
  - `st_cc` ← ed[63:60]
  - `st_fpc` ← ed[58:56]
  - `st_mode` ← ed[55:52]
  - `st_ia` ← ed[48:32]
  - `st_wk` ← ed[31:28]
  - `st_ra` ← ed[3]
  - `st_ma` ← ed[2]
- R9: At commit, `st_inh` becomes `st_inh` OR ed[26:24]. A zero in the doubleword never clears an inhibit bit.
- R10: `st_rp` loads ed[7:4] only if `instr[23]` (instruction bit 8) was 1. Otherwise it keeps its value.
- R11: Flags {`instr[21]`, `instr[20]`} (instruction bits 10, 11) select the interrupt action:
  - 00: no action.
  - 01: `pdf_clr` pulses with `done`, and `int_req` is never raised.
  - 10 or 11: after the second beat, `int_req` is raised with `int_op` equal to the flags. Both are held until `int_ready`, and the commit takes place in that cycle.
- R12: `done` is a single-cycle pulse. The status outputs change only in the cycle in which `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (honoured when idle) |
| instr | input | 32 | Instruction word; bits 31, 23, 21, 20 used |
| ptr_in | input | 64 | Status-stack pointer doubleword |
| mem_valid | output | 1 | Read address valid |
| mem_addr | output | 32 | Word read address |
| mem_ready | input | 1 | Memory accepts the beat; data valid this cycle |
| mem_rdata | input | 32 | Read data |
| int_req | output | 1 | Interrupt-level change request |
| int_op | output | 2 | Requested interrupt action |
| int_ready | input | 1 | Interrupt system accepts the request |
| pdf_clr | output | 1 | Pulse: reset the PDF flag |
| trap_valid | output | 1 | Trap pulse |
| trap_vec | output | 8 | Trap vector |
| trap_cc2 | output | 1 | Trap condition bit 2 |
| done | output | 1 | Operation committed |
| ptr_wr | output | 1 | Write back `ptr_out` |
| ptr_out | output | 64 | Updated pointer doubleword |
| st_cc | output | 4 | Condition code |
| st_fpc | output | 3 | Float-control bits |
| st_mode | output | 4 | Mode bits |
| st_ia | output | 17 | Instruction address |
| st_wk | output | 4 | Write key |
| st_inh | output | 3 | Interrupt-inhibit bits |
| st_rp | output | 4 | Register pointer |
| st_ra | output | 1 | RA bit |
| st_ma | output | 1 | MA bit |

## Verification
The hardest state to reach from the ports is a long stall in the interrupt wait after both beats have been read. The status and pointer must stay frozen throughout that stall, and a reset arriving during it must cancel the request. The bench's memory and interrupt responders take per-run stall counts, so they can hold `mem_ready` and `int_ready` low for a chosen number of cycles. The bench then checks the exact completion latency and the number of cycles `int_req` was held. A separate run parks the controller in the wait, applies reset, and checks that the request and all status outputs are gone.

// File: rtl/status_pull_ctrl.sv
module status_pull_ctrl #(
  parameter int          AW      = 32,
  parameter int          CW      = 15,
  parameter int          POP     = 28,
  parameter int          HI_OFF  = 24,
  parameter logic [AW-1:0] FIX_ADDR = 2,
  parameter logic [7:0]  EXC_VEC = 8'h4D,
  parameter logic [7:0]  NX_VEC  = 8'h40,
  localparam int         PW      = AW + 2*CW + 2
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [31:0]   instr,
  input  logic [PW-1:0] ptr_in,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  output logic          int_req,
  output logic [1:0]    int_op,
  input  logic          int_ready,
  output logic          pdf_clr,
  output logic          trap_valid,
  output logic [7:0]    trap_vec,
  output logic          trap_cc2,
  output logic          done,
  output logic          ptr_wr,
  output logic [PW-1:0] ptr_out,
  output logic [3:0]    st_cc,
  output logic [2:0]    st_fpc,
  output logic [3:0]    st_mode,
  output logic [16:0]   st_ia,
  output logic [3:0]    st_wk,
  output logic [2:0]    st_inh,
  output logic [3:0]    st_rp,
  output logic          st_ra,
  output logic          st_ma
);
  typedef enum logic [1:0] {IDLE, RD0, RD1, WINT} state_t;
  state_t st;

  logic          rpen_q, cl_q, ad_q;
  logic [PW-1:0] ptr_q;
  logic [31:0]   w0_q, w1_q;

  wire [CW-1:0] wc_in  = ptr_in[CW-1:0];
  wire [AW-1:0] tsa_q  = ptr_q[PW-1 -: AW];
  wire [CW-1:0] wc_q   = ptr_q[CW-1:0];
  wire          wch_q  = ptr_q[CW];
  wire [CW-1:0] sc_q   = ptr_q[2*CW:CW+1];
  wire          scf_q  = ptr_q[2*CW+1];
  wire          is_pop = wc_q != '0;

  wire [AW-1:0] a0 = is_pop ? tsa_q - AW'(HI_OFF) : FIX_ADDR;
  wire [AW-1:0] a1 = is_pop ? tsa_q + AW'(1)      : FIX_ADDR + AW'(1);

  wire [CW:0]   sc_sum  = {1'b0, sc_q} + (CW+1)'(POP);
  wire [PW-1:0] ptr_new = {tsa_q - AW'(POP), scf_q | sc_sum[CW], sc_sum[CW-1:0],
                           wch_q, wc_q - CW'(POP)};

  wire [63:0] ed = {w0_q, (st == RD1) ? mem_rdata : w1_q};
  wire commit = (st == RD1 && mem_ready && !cl_q) || (st == WINT && int_ready);

  assign mem_valid = (st == RD0) || (st == RD1);
  assign mem_addr  = (st == RD1) ? a1 : a0;
  assign int_req   = (st == WINT);
  assign int_op    = {cl_q, ad_q};

  logic unused_bits;
  assign unused_bits = ^{instr[30:24], instr[22], instr[19:0],
                         ed[59], ed[51:49], ed[27], ed[23:8], ed[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= IDLE;
      rpen_q <= 1'b0; cl_q <= 1'b0; ad_q <= 1'b0;
      ptr_q <= '0; w0_q <= '0; w1_q <= '0;
      done <= 1'b0; ptr_wr <= 1'b0; pdf_clr <= 1'b0;
      trap_valid <= 1'b0; trap_vec <= '0; trap_cc2 <= 1'b0;
      ptr_out <= '0;
      st_cc <= '0; st_fpc <= '0; st_mode <= '0; st_ia <= '0;
      st_wk <= '0; st_inh <= '0; st_rp <= '0; st_ra <= 1'b0; st_ma <= 1'b0;
    end else begin
      done       <= 1'b0;
      ptr_wr     <= 1'b0;
      pdf_clr    <= 1'b0;
      trap_valid <= 1'b0;
      trap_cc2   <= 1'b0;
      case (st)
        IDLE: if (start) begin
          rpen_q <= instr[23];
          cl_q   <= instr[21];
          ad_q   <= instr[20];
          ptr_q  <= ptr_in;
          if (instr[31]) begin
            trap_valid <= 1'b1;
            trap_vec   <= NX_VEC;
          end else if (wc_in != '0 && wc_in < CW'(POP)) begin
            trap_valid <= 1'b1;
            trap_vec   <= EXC_VEC;
            trap_cc2   <= 1'b1;
          end else begin
            st <= RD0;
          end
        end
        RD0: if (mem_ready) begin
          w0_q <= mem_rdata;
          st   <= RD1;
        end
        RD1: if (mem_ready) begin
          w1_q <= mem_rdata;
          if (cl_q) st <= WINT;
        end
        WINT: ;
        default: st <= IDLE;
      endcase
      if (commit) begin
        st      <= IDLE;
        st_cc   <= ed[63:60];
        st_fpc  <= ed[58:56];
        st_mode <= ed[55:52];
        st_ia   <= ed[48:32];
        st_wk   <= ed[31:28];
        st_inh  <= st_inh | ed[26:24];
        if (rpen_q) st_rp <= ed[7:4];
        st_ra   <= ed[3];
        st_ma   <= ed[2];
        if (is_pop) begin
          ptr_out <= ptr_new;
          ptr_wr  <= 1'b1;
        end
        pdf_clr <= !cl_q && ad_q;
        done    <= 1'b1;
      end
    end
  end

  // R7
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));

  // R11
  int_hold_chk: assert property (@(posedge clk) disable iff (rst)
    int_req && !int_ready |=> int_req && $stable(int_op));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  stat_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !done && !$past(rst) |-> $stable({st_cc, st_fpc, st_mode, st_ia, st_wk,
                                      st_inh, st_rp, st_ra, st_ma}));

  // R9
  inh_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (st_inh & $past(st_inh)) == $past(st_inh));

  // R3
  trap_excl_chk: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> !done && !ptr_wr && !mem_valid && !int_req);
endmodule

// File: tb/status_pull_ctrl_bench.sv
module status_pull_ctrl_bench;
  logic clk = 0, rst = 1, start = 0;
  logic [31:0] instr = '0;
  logic [63:0] ptr_in = '0;
  logic mem_valid, mem_ready = 0, int_req, int_ready = 0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic [1:0] int_op;
  logic pdf_clr, trap_valid, trap_cc2, done, ptr_wr, st_ra, st_ma;
  logic [7:0] trap_vec;
  logic [63:0] ptr_out;
  logic [3:0] st_cc, st_mode, st_wk, st_rp;
  logic [2:0] st_fpc, st_inh;
  logic [16:0] st_ia;

  always #5 clk = ~clk;

  status_pull_ctrl u_status_pull_ctrl (.*);

  typedef struct packed {
    logic [31:0] ins; logic [63:0] ptr; logic [31:0] w0; logic [31:0] w1; logic [1:0] kind;
  } vec_t;
  // kind: 0 fixed fetch, 1 stack pop, 2 word-count trap, 3 nonexistent trap
  localparam vec_t VT [8] = '{
    '{32'h0000_0000, 64'h0000_0100_0000_0000, 32'hA5C3_F0F1, 32'h7123_4567, 2'd0},
    '{32'h0010_0000, 64'h0000_2000_000A_0028, 32'h1234_5678, 32'h89AB_CDEF, 2'd1},
    '{32'h0000_0000, 64'h0000_3000_0000_0005, 32'h0,         32'h0,         2'd2},
    '{32'h8030_0000, 64'h0000_0100_0000_0000, 32'h0,         32'h0,         2'd3},
    '{32'h00B0_0000, 64'h0000_0040_7FF8_001C, 32'h0F0F_0F0F, 32'hF5F0_00FF, 2'd1},
    '{32'h0020_0000, 64'h0000_0500_0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 2'd0},
    '{32'h0000_0000, 64'h0000_3000_0000_001B, 32'h0,         32'h0,         2'd2},
    '{32'h0000_0000, 64'h0000_0010_8005_801E, 32'h0000_0000, 32'h0000_0000, 2'd1}
  };

  int checks = 0, failures = 0, wd = 0;
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin failures++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      failures++;
      $display("FAIL R12 watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  logic [31:0] ea0, ea1, vw0, vw1, hold_addr, seen0, seen1;
  int nbeats, m_stall, i_stall, int_hi, hold_err;
  bit int_seen, holding;
  logic [1:0] seen_op;
  always @(negedge clk) begin
    if (mem_valid) begin
      if (m_stall > 0) begin
        m_stall--; mem_ready = 0;
        if (holding && mem_addr != hold_addr) hold_err++;
        holding = 1; hold_addr = mem_addr;
      end else begin
        holding = 0; mem_ready = 1;
        mem_rdata = (mem_addr == ea0) ? vw0 : (mem_addr == ea1) ? vw1 : 32'hBAD0_BAD0;
        if (nbeats == 0) seen0 = mem_addr; else seen1 = mem_addr;
        nbeats++;
      end
    end else mem_ready = 0;
    if (int_req) begin
      int_hi++;
      if (i_stall > 0) begin i_stall--; int_ready = 0; end
      else begin int_ready = 1; int_seen = 1; seen_op = int_op; end
    end else int_ready = 0;
  end

  logic [3:0] m_cc, m_mode, m_wk, m_rp; logic [2:0] m_fpc, m_inh; logic [16:0] m_ia; logic m_ra, m_ma;
  task automatic model_clear();
    m_cc = 0; m_mode = 0; m_wk = 0; m_rp = 0; m_fpc = 0; m_inh = 0; m_ia = 0; m_ra = 0; m_ma = 0;
  endtask
  task automatic model_load(input logic [63:0] ed, input bit rpen);
    m_cc = ed[63:60]; m_fpc = ed[58:56]; m_mode = ed[55:52]; m_ia = ed[48:32];
    m_wk = ed[31:28]; m_inh = m_inh | ed[26:24]; if (rpen) m_rp = ed[7:4];
    m_ra = ed[3]; m_ma = ed[2];
  endtask
  function automatic logic [63:0] stat_act();
    return 64'({st_cc, st_fpc, st_mode, st_ia, st_wk, st_inh, st_rp, st_ra, st_ma});
  endfunction
  function automatic logic [63:0] stat_exp();
    return 64'({m_cc, m_fpc, m_mode, m_ia, m_wk, m_inh, m_rp, m_ra, m_ma});
  endfunction
  function automatic logic [63:0] ptr_exp(input logic [63:0] p);
    logic [15:0] s;
    s = {1'b0, p[30:16]} + 16'd28;
    return {p[63:32] - 32'd28, p[31] | s[15], s[14:0], p[15], p[14:0] - 15'd28};
  endfunction

  int cyc;
  bit g_done, g_trap, g_cc2, g_pdf, g_wr;
  logic [7:0] g_vec; logic [63:0] g_ptr;
  task automatic run(input vec_t v, input int ms, input int is);
    if (v.ptr[14:0] != 0) begin ea0 = v.ptr[63:32] - 32'd24; ea1 = v.ptr[63:32] + 32'd1; end
    else begin ea0 = 32'd2; ea1 = 32'd3; end
    vw0 = v.w0; vw1 = v.w1; nbeats = 0; int_seen = 0; int_hi = 0; hold_err = 0;
    holding = 0; m_stall = ms; i_stall = is; seen0 = 'x; seen1 = 'x;
    @(negedge clk); instr = v.ins; ptr_in = v.ptr; start = 1;
    cyc = 0;
    do begin @(negedge clk); start = 0; cyc++; end
    while (!done && !trap_valid && cyc < 200);
    g_done = done; g_trap = trap_valid; g_vec = trap_vec; g_cc2 = trap_cc2;
    g_pdf = pdf_clr; g_wr = ptr_wr; g_ptr = ptr_out;
  endtask

  logic [63:0] last_ptr;
  initial begin
    model_clear();
    m_stall = 0; i_stall = 0; nbeats = 0; last_ptr = '0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!mem_valid && !int_req && !done && !trap_valid && !ptr_wr && !pdf_clr, "R1 idle outputs",
        {mem_valid, int_req, done, trap_valid, ptr_wr, pdf_clr}, 0);
    chk(stat_act() == 0 && ptr_out == 0, "R1 status zero", stat_act(), 0);

    for (int i = 0; i < 8; i++) begin
      vec_t v;
      v = VT[i];
      run(v, 0, 0);
      if (v.kind >= 2) begin
        chk(g_trap && !g_done, "R2/R3 trap raised", {g_trap, g_done}, 2'b10);
        chk(g_vec == (v.kind == 3 ? 8'h40 : 8'h4D), v.kind == 3 ? "R2 vector" : "R3 vector", g_vec, v.kind == 3 ? 8'h40 : 8'h4D);
        chk(g_cc2 == (v.kind == 2), "R3 cc2 bit", g_cc2, v.kind == 2);
        chk(nbeats == 0, "R2/R3 no read", nbeats, 0);
        chk(stat_act() == stat_exp() && ptr_out == last_ptr, "R3 state unchanged", stat_act(), stat_exp());
      end else begin
        model_load({v.w0, v.w1}, v.ins[23]);
        chk(g_done && !g_trap, "R12 done", {g_done, g_trap}, 2'b10);
        chk(nbeats == 2 && seen0 == ea0 && seen1 == ea1, v.kind == 0 ? "R4 fixed addrs" : "R5 stack addrs",
            {seen0, seen1}, {ea0, ea1});
        chk(stat_act() == stat_exp(), "R8/R9/R10 status load", stat_act(), stat_exp());
        chk(g_pdf == (v.ins[21:20] == 2'b01), "R11 pdf pulse", g_pdf, v.ins[21:20] == 2'b01);
        chk(int_seen == v.ins[21] && (!v.ins[21] || seen_op == v.ins[21:20]), "R11 int request",
            {int_seen, seen_op}, {v.ins[21], v.ins[21:20]});
        if (v.kind == 1) begin
          chk(g_wr && g_ptr == ptr_exp(v.ptr), "R5/R6 pointer update", g_ptr, ptr_exp(v.ptr));
          last_ptr = ptr_exp(v.ptr);
        end else
          chk(!g_wr && ptr_out == last_ptr, "R4 pointer untouched", ptr_out, last_ptr);
      end
      @(negedge clk);
      chk(!done && !trap_valid, "R12 single pulse", {done, trap_valid}, 0);
    end

    // R7 R11 stalls on both ports
    run(VT[4], 3, 4);
    model_load({VT[4].w0, VT[4].w1}, 1'b1);
    chk(g_done && cyc == 11, "R7/R11 stalled latency", cyc, 11);
    chk(hold_err == 0, "R7 address held", hold_err, 0);
    chk(int_hi == 5, "R11 request held", int_hi, 5);
    chk(stat_act() == stat_exp() && g_ptr == ptr_exp(VT[4].ptr), "R6 stalled commit", g_ptr, ptr_exp(VT[4].ptr));

    // R1 reset while waiting for the interrupt system
    ea0 = 2; ea1 = 3; vw0 = 32'h5555_5555; vw1 = 32'h0700_0000; nbeats = 0; i_stall = 1000;
    @(negedge clk); instr = 32'h0020_0000; ptr_in = '0; start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    chk(int_req && stat_act() == stat_exp(), "R11 waiting, status frozen", {int_req, stat_act()}, {1'b1, stat_exp()});
    rst = 1; repeat (2) @(negedge clk); rst = 0; i_stall = 0;
    @(negedge clk);
    model_clear();
    chk(!int_req && !mem_valid && !done, "R1 request cancelled", {int_req, mem_valid, done}, 0);
    chk(stat_act() == 0 && ptr_out == 0, "R1 status cleared", stat_act(), 0);
    last_ptr = '0;

    run(VT[0], 0, 0);
    model_load({VT[0].w0, VT[0].w1}, 1'b0);
    chk(g_done && stat_act() == stat_exp(), "R8 after reset", stat_act(), stat_exp());

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule